// File: doc/BRIEF.md
# Segmented SECDED Link Codec

This block is the error-control pair that sits on one router-to-router link. On the sending side it takes a 114-bit packet and cuts it into seven pieces: two header pieces of 17 bits and five payload pieces of 16 bits. Each piece gets its own single-error-correcting, double-error-detecting Hamming code: a (23,17) code for the header pieces and a (22,16) code for the payload pieces. The coded bits of the seven pieces are then spread bit by bit, in round-robin order, over a 156-bit link word. The word carries 42 check bits in total.

On the receiving side the decoder takes the word straight from the receiving input register. Because it checks the register contents, an upset in the register is covered as well as an upset on the wires. It undoes the interleave and decodes every piece on its own. It returns the repaired packet, a per-piece corrected flag, a per-piece uncorrectable flag and the OR of the uncorrectable flags. A separate controller uses those flags to request a retransmission. Both directions are purely combinational.

Interleaving means that a burst of up to seven adjacent corrupted link bits hits seven different pieces. Each piece then sees one error, and the whole burst is repaired.

Top module: `link_codec`

## Requirements
- R1: Piece s (s = 0,1 header; 2..6 payload) takes packet bits [16:0], [33:17], [49:34], [65:50], [81:66], [97:82] and [113:98] in that order. Coded bit j of piece s is carried on link bit 7*j+s. Header pieces have 23 coded bits and payload pieces have 22.
- R2: Within a piece, coded bit 0 makes the XOR of all coded bits zero. Coded bits 1, 2, 4, 8 and 16 are check bits: for every p, the XOR of all coded bits 1..n-1 whose index has bit p set is zero. The data bits fill the remaining indices 3, 5, 6, 7, 9, ... in ascending order, LSB first.
- R3: A link word with no error returns the original packet, with all corrected and uncorrectable flags low.
- R4: One flipped bit anywhere in a piece, check bits included, is repaired. That piece's corrected flag (bit s of the flag vector) goes high and its uncorrectable flag stays low.
- R5: One flipped bit in each of the seven pieces at once is fully repaired, and the corrected vector reads 7'h7f.
- R6: Two flipped bits inside one piece raise that piece's uncorrectable flag with its corrected flag low. The piece's data bits are then passed on exactly as received, with no bit flipped.
- R7: The summary uncorrectable output is high exactly when any per-piece uncorrectable flag is high.
- R8: Any run of seven consecutive flipped link bits is fully repaired, and all seven corrected flags go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pkt_i | input | 114 | Raw packet to be coded |
| link_o | output | 156 | Interleaved coded word for the link |
| link_i | input | 156 | Coded word from the receiving input register |
| pkt_o | output | 114 | Repaired packet |
| sec_o | output | 7 | Per-piece single error corrected |
| ded_o | output | 7 | Per-piece double error detected |
| ded_any_o | output | 1 | OR of all per-piece double error flags |

## Verification
The hardest case to reach from the ports is a piece receiving two errors while its neighbours stay clean. Adjacent link bits belong to different pieces, so the two flips must be placed seven bits apart, or a multiple of seven, on the link. The stimulus builds reference link words in the bench and flips every pair of coded bits of one header piece and of one payload piece. It then checks that only that piece's uncorrectable flag rises and that its data passes through raw. Sweeps over every single bit, every seven-bit burst position and one-error-per-piece patterns cover the repair paths.

// File: rtl/lc_pkg.sv
package lc_pkg;

  function automatic bit is_pow2(int q);
    return (q > 0) && ((q & (q - 1)) == 0);
  endfunction

  // check bits needed so that 2^r covers k data + r check positions
  function automatic int parity_bits(int k);
    int r;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

  function automatic int secded_n(int k);
    return k + parity_bits(k) + 1;
  endfunction

  function automatic int seg_k(int s, int h, int hk, int pk);
    return (s < h) ? hk : pk;
  endfunction

  function automatic int seg_n(int s, int h, int hk, int pk);
    return secded_n(seg_k(s, h, hk, pk));
  endfunction

  function automatic int seg_doff(int s, int h, int hk, int pk);
    return (s < h) ? s * hk : h * hk + (s - h) * pk;
  endfunction

  function automatic int seg_coff(int s, int h, int hk, int pk);
    return (s < h) ? s * secded_n(hk) : h * secded_n(hk) + (s - h) * secded_n(pk);
  endfunction

  // round-robin slot of coded bit j of segment s
  function automatic int link_idx(int s, int j, int nseg, int h, int hk, int pk);
    int idx;
    idx = 0;
    for (int t = 0; t < j; t++)
      for (int u = 0; u < nseg; u++)
        if (seg_n(u, h, hk, pk) > t) idx++;
    for (int u = 0; u < s; u++)
      if (seg_n(u, h, hk, pk) > j) idx++;
    return idx;
  endfunction

endpackage

// File: rtl/lc_secded_enc.sv
module lc_secded_enc import lc_pkg::*; #(
  parameter int K = 16,
  localparam int R = parity_bits(K),
  localparam int N = K + R + 1
) (
  input  logic [K-1:0] data_i,
  output logic [N-1:0] code_o
);

  logic [N-1:0] body;
  logic [N-1:0] cw;

  assign body[0] = 1'b0;
  for (genvar q = 1; q < N; q++) begin : g_pos
    if (is_pow2(q)) begin : g_chk
      assign body[q] = 1'b0;
    end else begin : g_dat
      localparam int DI = q - 1 - $clog2(q + 1);
      assign body[q] = data_i[DI];
    end
  end

  always_comb begin : p_enc
    logic par;
    cw = body;
    for (int p = 0; p < R; p++) begin
      par = 1'b0;
      for (int q = 1; q < N; q++)
        if (q[p]) par ^= body[q];
      cw[1 << p] = par;
    end
    cw[0] = ^cw[N-1:1];
  end

  assign code_o = cw;

  // independent recheck of the emitted word
  logic [R-1:0] chk_syn;
  always_comb begin
    chk_syn = '0;
    for (int p = 0; p < R; p++)
      for (int q = 1; q < N; q++)
        if (q[p]) chk_syn[p] ^= code_o[q];
  end

  always_comb begin
    assert_code_valid_R2: assert (chk_syn == '0 && (^code_o) == 1'b0);
  end

endmodule

// File: rtl/lc_secded_dec.sv
module lc_secded_dec import lc_pkg::*; #(
  parameter int K = 16,
  localparam int R = parity_bits(K),
  localparam int N = K + R + 1
) (
  input  logic [N-1:0] code_i,
  output logic [K-1:0] data_o,
  output logic         sec_o,
  output logic         ded_o
);

  logic [R-1:0] syn;
  logic         ovf;
  logic [N-1:0] fixed;
  logic         sec_q, ded_q;

  always_comb begin
    syn = '0;
    for (int p = 0; p < R; p++)
      for (int q = 1; q < N; q++)
        if (q[p]) syn[p] ^= code_i[q];
    ovf   = ^code_i;
    fixed = code_i;
    sec_q = 1'b0;
    ded_q = 1'b0;
    if (syn != '0) begin
      if (!ovf) begin
        ded_q = 1'b1;
      end else if (int'(syn) < N) begin
        sec_q = 1'b1;
        fixed[syn] = ~fixed[syn];
      end else begin
        ded_q = 1'b1;  // syndrome points outside the segment
      end
    end else if (ovf) begin
      sec_q = 1'b1;    // overall parity bit itself flipped
      fixed[0] = ~fixed[0];
    end
  end

  for (genvar q = 3; q < N; q++) begin : g_out
    if (!is_pow2(q)) begin : g_dat
      localparam int DI = q - 1 - $clog2(q + 1);
      assign data_o[DI] = fixed[q];
    end
  end

  assign sec_o = sec_q;
  assign ded_o = ded_q;

  logic [R-1:0] fix_syn;
  always_comb begin
    fix_syn = '0;
    for (int p = 0; p < R; p++)
      for (int q = 1; q < N; q++)
        if (q[p]) fix_syn[p] ^= fixed[q];
  end

  always_comb begin
    assert_flag_excl_R6: assert (!(sec_q && ded_q));
    if (sec_q) begin
      assert_sec_clean_R4: assert (fix_syn == '0 && (^fixed) == 1'b0);
      assert_sec_onebit_R4: assert ($countones(fixed ^ code_i) == 1);
    end
    if (ded_q) begin
      assert_ded_raw_R6: assert (fixed == code_i);
    end
  end

endmodule

// File: rtl/lc_shuffle.sv
module lc_shuffle import lc_pkg::*; #(
  parameter int HDR_SEGS = 2,
  parameter int PAY_SEGS = 5,
  parameter int HDR_K    = 17,
  parameter int PAY_K    = 16,
  parameter bit INVERSE  = 1'b0,
  localparam int NSEG = HDR_SEGS + PAY_SEGS,
  localparam int W    = HDR_SEGS * secded_n(HDR_K) + PAY_SEGS * secded_n(PAY_K)
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int SN   = seg_n(s, HDR_SEGS, HDR_K, PAY_K);
    localparam int BASE = seg_coff(s, HDR_SEGS, HDR_K, PAY_K);
    for (genvar j = 0; j < SN; j++) begin : g_bit
      localparam int L = link_idx(s, j, NSEG, HDR_SEGS, HDR_K, PAY_K);
      if (INVERSE) begin : g_inv
        assign out_o[BASE+j] = in_i[L];
      end else begin : g_fwd
        assign out_o[L] = in_i[BASE+j];
      end
    end
  end

  always_comb begin
    assert_perm_R1: assert ($countones(in_i) == $countones(out_o));
  end

endmodule

// File: rtl/link_codec.sv
module link_codec import lc_pkg::*; #(
  parameter int HDR_SEGS = 2,
  parameter int PAY_SEGS = 5,
  parameter int HDR_K    = 17,
  parameter int PAY_K    = 16,
  localparam int NSEG   = HDR_SEGS + PAY_SEGS,
  localparam int PKT_W  = HDR_SEGS * HDR_K + PAY_SEGS * PAY_K,
  localparam int LINK_W = HDR_SEGS * secded_n(HDR_K) + PAY_SEGS * secded_n(PAY_K)
) (
  input  logic [PKT_W-1:0]  pkt_i,
  output logic [LINK_W-1:0] link_o,
  input  logic [LINK_W-1:0] link_i,
  output logic [PKT_W-1:0]  pkt_o,
  output logic [NSEG-1:0]   sec_o,
  output logic [NSEG-1:0]   ded_o,
  output logic              ded_any_o
);

  logic [LINK_W-1:0] enc_flat;
  logic [LINK_W-1:0] dec_flat;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int K    = seg_k(s, HDR_SEGS, HDR_K, PAY_K);
    localparam int N    = secded_n(K);
    localparam int DOFF = seg_doff(s, HDR_SEGS, HDR_K, PAY_K);
    localparam int COFF = seg_coff(s, HDR_SEGS, HDR_K, PAY_K);

    lc_secded_enc #(.K(K)) u_enc (
      .data_i (pkt_i[DOFF +: K]),
      .code_o (enc_flat[COFF +: N])
    );

    lc_secded_dec #(.K(K)) u_dec (
      .code_i (dec_flat[COFF +: N]),
      .data_o (pkt_o[DOFF +: K]),
      .sec_o  (sec_o[s]),
      .ded_o  (ded_o[s])
    );
  end

  lc_shuffle #(
    .HDR_SEGS(HDR_SEGS), .PAY_SEGS(PAY_SEGS), .HDR_K(HDR_K), .PAY_K(PAY_K), .INVERSE(1'b0)
  ) u_ilv (
    .in_i  (enc_flat),
    .out_o (link_o)
  );

  lc_shuffle #(
    .HDR_SEGS(HDR_SEGS), .PAY_SEGS(PAY_SEGS), .HDR_K(HDR_K), .PAY_K(PAY_K), .INVERSE(1'b1)
  ) u_dilv (
    .in_i  (link_i),
    .out_o (dec_flat)
  );

  assign ded_any_o = |ded_o;

endmodule

// File: tb/link_codec_bench.sv
module link_codec_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic [113:0] pkt_r = '0;
  logic [155:0] link_r = '0;
  logic [155:0] link_o;
  logic [113:0] pkt_o;
  logic [6:0]   sec_o, ded_o;
  logic         ded_any_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_codec u_link_codec (
    .pkt_i(pkt_r), .link_o(link_o), .link_i(link_r), .pkt_o(pkt_o),
    .sec_o(sec_o), .ded_o(ded_o), .ded_any_o(ded_any_o)
  );

  function automatic int slen(int s);  return (s < 2) ? 23 : 22; endfunction
  function automatic int doff(int s);  return (s < 2) ? s * 17 : 34 + (s - 2) * 16; endfunction

  // reference coder built from R1/R2
  function automatic logic [155:0] ref_enc(logic [113:0] p);
    logic [155:0] l;
    l = '0;
    for (int s = 0; s < 7; s++) begin
      int n; int k; logic [22:0] cw; logic x;
      n = slen(s); k = 0; cw = '0;
      for (int q = 1; q < n; q++)
        if ((q & (q - 1)) != 0) begin cw[q] = p[doff(s) + k]; k++; end
      for (int b = 0; b < 5; b++) begin
        x = 1'b0;
        for (int q = 1; q < n; q++) if (q[b]) x ^= cw[q];
        cw[1 << b] = x;
      end
      cw[0] = ^cw;
      for (int j = 0; j < n; j++) l[7*j + s] = cw[j];
    end
    return l;
  endfunction

  // raw data bits carried in a link word (R1/R2 placement)
  function automatic logic [113:0] ref_data(logic [155:0] l);
    logic [113:0] p;
    p = '0;
    for (int s = 0; s < 7; s++) begin
      int k; k = 0;
      for (int q = 1; q < slen(s); q++)
        if ((q & (q - 1)) != 0) begin p[doff(s) + k] = l[7*q + s]; k++; end
    end
    return p;
  endfunction

  function automatic logic [113:0] rnd_pkt();
    return 114'({$urandom, $urandom, $urandom, $urandom});
  endfunction

  task automatic check(input bit ok, input string req, input logic [155:0] act, input logic [155:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [113:0] p, input logic [155:0] l);
    @(posedge clk);
    pkt_r = p;
    link_r = l;
    @(negedge clk);
  endtask

  task automatic clean_round(input logic [113:0] p);
    logic [155:0] e;
    e = ref_enc(p);
    drive(p, e);
    check(link_o == e, "R1/R2 encode", link_o, e);
    check(pkt_o == p, "R3 clean data", 156'(pkt_o), 156'(p));
    check(sec_o == 7'd0 && ded_o == 7'd0, "R3 clean flags", 156'({sec_o, ded_o}), 156'(0));
    check(ded_any_o == 1'b0, "R7 clean summary", 156'(ded_any_o), 156'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [113:0] p;
    logic [155:0] e, l;

    // quiescent state: all-zero inputs
    drive('0, '0);
    check(link_o == '0, "R2 zero word", link_o, '0);
    check(pkt_o == '0 && sec_o == '0 && ded_o == '0 && !ded_any_o, "R3 zero state",
          156'({pkt_o, sec_o, ded_o}), '0);

    clean_round({114{1'b1}});
    for (int i = 0; i < 114; i++) clean_round(114'(1) << i);
    for (int i = 0; i < 20; i++) clean_round(rnd_pkt());

    // every single-bit error position
    p = rnd_pkt(); e = ref_enc(p);
    for (int i = 0; i < 156; i++) begin
      drive(p, e ^ (156'(1) << i));
      check(pkt_o == p, "R4 single data", 156'(pkt_o), 156'(p));
      check(sec_o == (7'(1) << (i % 7)) && ded_o == 7'd0, "R4 single flags",
            156'({sec_o, ded_o}), 156'({7'(1) << (i % 7), 7'd0}));
    end

    // one error per segment at once
    for (int r = 0; r < 12; r++) begin
      p = rnd_pkt(); l = ref_enc(p);
      for (int s = 0; s < 7; s++) l[7*((r*3 + s*5) % slen(s)) + s] ^= 1'b1;
      drive(p, l);
      check(pkt_o == p, "R5 seven singles data", 156'(pkt_o), 156'(p));
      check(sec_o == 7'h7f && ded_o == 7'd0, "R5 seven singles flags",
            156'({sec_o, ded_o}), 156'({7'h7f, 7'd0}));
    end

    // seven-bit bursts at every offset
    p = rnd_pkt(); e = ref_enc(p);
    for (int st = 0; st <= 149; st++) begin
      drive(p, e ^ (156'(7'h7f) << st));
      check(pkt_o == p, "R8 burst data", 156'(pkt_o), 156'(p));
      check(sec_o == 7'h7f && ded_o == 7'd0, "R8 burst flags",
            156'({sec_o, ded_o}), 156'({7'h7f, 7'd0}));
    end

    // every double error within one header and one payload segment
    p = rnd_pkt(); e = ref_enc(p);
    for (int pass = 0; pass < 2; pass++) begin
      int s; s = (pass == 0) ? 0 : 4;
      for (int a = 0; a < slen(s); a++)
        for (int b = a + 1; b < slen(s); b++) begin
          l = e;
          l[7*a + s] ^= 1'b1;
          l[7*b + s] ^= 1'b1;
          drive(p, l);
          check(ded_o == (7'(1) << s) && sec_o == 7'd0, "R6 double flags",
                156'({sec_o, ded_o}), 156'({7'd0, 7'(1) << s}));
          check(pkt_o == ref_data(l), "R6 double raw data", 156'(pkt_o), 156'(ref_data(l)));
          check(ded_any_o == 1'b1, "R7 summary on double", 156'(ded_any_o), 156'(1));
        end
    end

    // doubles in two segments at once
    for (int r = 0; r < 8; r++) begin
      p = rnd_pkt(); l = ref_enc(p);
      l[7*r + 1] ^= 1'b1; l[7*(r + 9) + 1] ^= 1'b1;
      l[7*(r + 2) + 5] ^= 1'b1; l[7*(r + 13) + 5] ^= 1'b1;
      drive(p, l);
      check(ded_o == 7'b0100010 && sec_o == 7'd0, "R7 two-segment doubles",
            156'({sec_o, ded_o}), 156'({7'd0, 7'b0100010}));
      check(ded_any_o == 1'b1, "R7 summary two segments", 156'(ded_any_o), 156'(1));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule